// File: doc/BRIEF.md
# Dual-Port Word Memory with Per-Port Access Control

This block is a shared word store with two fully independent access ports, called left and right. It is meant for two agents, such as two processors, that swap messages or status words through common storage. Both ports have the same signal set and can be used in the same clock cycle. Each port decodes three active-low controls: a select, a direction (high for read, low for write) and a drive enable. From these it chooses one of five modes.

The memory is a synchronous model. On each rising clock edge a port samples its controls, its address and its hold input. A write updates the array on that edge. A read returns its word one cycle later, together with a valid flag. When the valid flag is low, the data output is forced to zero, which stands in for a released bus.

The hold input comes from an external arbiter. While it is asserted, the port cannot write.

Each port has a small state machine with five states. The state records the mode decoded at the last edge:

| State | Entered when | Port output |
|---|---|---|
| `MODE_IDLE` | select is high (powered down) | not driven |
| `MODE_READ` | select low, direction high, drive enable low | drives the word |
| `MODE_HOLD` | select low, direction high, drive enable high | not driven |
| `MODE_WRITE` | select low, direction low, hold low | not driven |
| `MODE_BLOCKED` | select low, direction low, hold high | not driven |

Every state can move to any of the five states at each edge. The move depends only on the newly sampled controls:
- IDLE→READ
- READ→WRITE
- WRITE→HOLD
- and so on, for all pairs.

Reset places both ports in `MODE_IDLE`.

Top module: `dpr_dual_port_ram`

## Requirements
- R1: After reset, both ports show valid low and data zero.
- R2: When a port's select is high, no word is written, whatever its direction and drive enable are. The cycle after such a sample, that port shows valid low and data zero.
- R3: When select and direction are both low and hold is low, the port's write data is stored at its address on that edge. Drive enable has no effect on this.
- R4: In the cycle after a write sample, the port's valid output is low even if drive enable was low.
- R5: When select is low, direction is high and drive enable is low, the next cycle shows valid high and the word stored at the sampled address.
- R6: When select is low, direction is high and drive enable is high, the next cycle shows valid low and data zero. Whenever valid is low, the data output is zero.
- R7: A port whose hold input is high at the edge does not write. The old word stays in place.
- R8: If both ports write the same address on the same edge and neither is held, the left port's data is stored.
- R9: A read on one port from an address that the other port writes on the same edge returns the old word. A read on a later edge returns the new word.
- R10: A write lasts only for edges where select and direction are both low. Once either control returns high, later write data is not stored.
- R11: The two ports work at the same time. A write on one port and a read at a different address on the other port both complete on the same edge.
- R12: Words are DATA_W bits wide (8 or 9, default 9). All DATA_W bits, including the top bit, are stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_addr | input | 12 | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_ce_n | input | 1 | Left select, active low |
| l_rw_n | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left drive enable, active low |
| l_busy | input | 1 | Left hold from arbiter, active high, blocks writes |
| l_rdata | output | DATA_W | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid (drive enable) |
| r_addr | input | 12 | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_ce_n | input | 1 | Right select, active low |
| r_rw_n | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right drive enable, active low |
| r_busy | input | 1 | Right hold from arbiter, active high, blocks writes |
| r_rdata | output | DATA_W | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid (drive enable) |

## Verification
The hardest cases to reach are the two that need both ports on the same edge. These are the same-address collision, where the left port must win, and the read-during-write, where the old word must come back. The bench reaches them by setting up both ports in the same falling-edge slot, so that they share one rising edge. It then reads the location back on a later cycle to tell old data from new. Ignored writes, whether from a deselected port, a held port or a closed write window, are checked only through later reads at the ports.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE    = 3'd0,
        MODE_READ    = 3'd1,
        MODE_HOLD    = 3'd2,
        MODE_WRITE   = 3'd3,
        MODE_BLOCKED = 3'd4
    } port_mode_e;

    // Translate the sampled active-low controls into a port mode.
    function automatic port_mode_e decode_mode(
        input logic sel_n,
        input logic dir_rd,
        input logic drv_n,
        input logic hold
    );
        port_mode_e m;
        if (sel_n)       m = MODE_IDLE;
        else if (!dir_rd) m = hold ? MODE_BLOCKED : MODE_WRITE;
        else if (drv_n)  m = MODE_HOLD;
        else             m = MODE_READ;
        return m;
    endfunction

endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              dir_rd,
    input  logic              drv_n,
    input  logic              hold,
    input  logic [DATA_W-1:0] word_q,
    output logic              wr_go,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_ok
);

    port_mode_e mode_d;
    port_mode_e mode_q;

    always_comb begin
        mode_d = decode_mode(sel_n, dir_rd, drv_n, hold);
    end

    // Write strobe goes straight to the array for this edge.
    assign wr_go = (mode_d == MODE_WRITE);

    // State register: the mode decoded at the last edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_IDLE;
        else        mode_q <= mode_d;
    end

    // Output process: only a completed read drives the word.
    always_comb begin
        rd_ok   = 1'b0;
        rd_word = '0;
        unique case (mode_q)
            MODE_READ: begin
                rd_ok   = 1'b1;
                rd_word = word_q;
            end
            MODE_IDLE, MODE_HOLD, MODE_WRITE, MODE_BLOCKED: begin
                rd_ok   = 1'b0;
                rd_word = '0;
            end
            default: begin
                rd_ok   = 1'b0;
                rd_word = '0;
            end
        endcase
    end

endmodule

// File: rtl/dpr_mem_array.sv
module dpr_mem_array #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_we,
    input  logic [DATA_W-1:0] a_wd,
    output logic [DATA_W-1:0] a_q,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_we,
    input  logic [DATA_W-1:0] b_wd,
    output logic [DATA_W-1:0] b_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Reads capture the pre-edge contents; port A is written last so it wins.
    always_ff @(posedge clk) begin
        a_q <= cells[a_addr];
        b_q <= cells[b_addr];
        if (b_we) cells[b_addr] <= b_wd;
        if (a_we) cells[a_addr] <= a_wd;
    end

endmodule

// File: rtl/dpr_dual_port_ram.sv
module dpr_dual_port_ram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic              l_busy,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic              r_busy,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);

    logic              l_we;
    logic              r_we;
    logic [DATA_W-1:0] l_q;
    logic [DATA_W-1:0] r_q;

    dpr_port_ctrl #(.DATA_W(DATA_W)) u_left (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (l_ce_n),
        .dir_rd (l_rw_n),
        .drv_n  (l_oe_n),
        .hold   (l_busy),
        .word_q (l_q),
        .wr_go  (l_we),
        .rd_word(l_rdata),
        .rd_ok  (l_rvalid)
    );

    dpr_port_ctrl #(.DATA_W(DATA_W)) u_right (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (r_ce_n),
        .dir_rd (r_rw_n),
        .drv_n  (r_oe_n),
        .hold   (r_busy),
        .word_q (r_q),
        .wr_go  (r_we),
        .rd_word(r_rdata),
        .rd_ok  (r_rvalid)
    );

    // Left port sits on the priority side of the array.
    dpr_mem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .a_addr(l_addr),
        .a_we  (l_we),
        .a_wd  (l_wdata),
        .a_q   (l_q),
        .b_addr(r_addr),
        .b_we  (r_we),
        .b_wd  (r_wdata),
        .b_q   (r_q)
    );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_ce_n,
    input logic              l_rw_n,
    input logic              l_oe_n,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_rvalid,
    input logic              r_ce_n,
    input logic              r_rw_n,
    input logic              r_oe_n,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_rvalid
);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(l_ce_n) |-> !l_rvalid);

    p_write_mutes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(r_ce_n) && !$past(r_rw_n)) |-> !r_rvalid);

    p_read_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(l_ce_n) && $past(l_rw_n) && !$past(l_oe_n)) |-> l_rvalid);

    p_drv_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(r_oe_n) |-> !r_rvalid);

    p_zero_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rvalid |-> (l_rdata == '0));

    p_zero_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rvalid |-> (r_rdata == '0));

endmodule

bind dpr_dual_port_ram dpr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_ce_n  (l_ce_n),
    .l_rw_n  (l_rw_n),
    .l_oe_n  (l_oe_n),
    .l_rdata (l_rdata),
    .l_rvalid(l_rvalid),
    .r_ce_n  (r_ce_n),
    .r_rw_n  (r_rw_n),
    .r_oe_n  (r_oe_n),
    .r_rdata (r_rdata),
    .r_rvalid(r_rvalid)
);

// File: tb/dpr_dual_port_ram_tb_top.sv
module dpr_dual_port_ram_tb_top;

    localparam int DW = 9;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic          l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1, l_busy = 1'b0;
    logic          r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1, r_busy = 1'b0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_rvalid, r_rvalid;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dpr_dual_port_ram #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_ce_n(l_ce_n), .l_rw_n(l_rw_n),
        .l_oe_n(l_oe_n), .l_busy(l_busy), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_ce_n(r_ce_n), .r_rw_n(r_rw_n),
        .r_oe_n(r_oe_n), .r_busy(r_busy), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drv_l(input logic ce, input logic rw, input logic oe, input logic bz,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_ce_n = ce; l_rw_n = rw; l_oe_n = oe; l_busy = bz; l_addr = a; l_wdata = d;
    endtask

    task automatic drv_r(input logic ce, input logic rw, input logic oe, input logic bz,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_ce_n = ce; r_rw_n = rw; r_oe_n = oe; r_busy = bz; r_addr = a; r_wdata = d;
    endtask

    task automatic idle_both();
        drv_l(1, 1, 1, 0, '0, '0);
        drv_r(1, 1, 1, 0, '0, '0);
        @(negedge clk);
    endtask

    // One cycle: inputs are already set; step to the next falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic read_l(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        drv_l(0, 1, 0, 0, a, '0); step();
        chk({req, " left valid"}, 16'(l_rvalid), 16'd1);
        chk({req, " left data"}, 16'(l_rdata), 16'(exp));
        drv_l(1, 1, 1, 0, '0, '0);
    endtask

    task automatic read_r(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        drv_r(0, 1, 0, 0, a, '0); step();
        chk({req, " right valid"}, 16'(r_rvalid), 16'd1);
        chk({req, " right data"}, 16'(r_rdata), 16'(exp));
        drv_r(1, 1, 1, 0, '0, '0);
    endtask

    task automatic t_reset();
        chk("R1 left valid", 16'(l_rvalid), 16'd0);
        chk("R1 left data", 16'(l_rdata), 16'd0);
        chk("R1 right valid", 16'(r_rvalid), 16'd0);
        chk("R1 right data", 16'(r_rdata), 16'd0);
    endtask

    task automatic t_write_read();
        drv_l(0, 0, 0, 0, 12'h010, 9'h1A5); step();
        chk("R4 left valid during write", 16'(l_rvalid), 16'd0);
        drv_l(0, 0, 1, 0, 12'hFFF, 9'h100); step();
        idle_both();
        read_l(12'h010, 9'h1A5, "R3 R5");
        read_r(12'hFFF, 9'h100, "R3 R12 top bit");
    endtask

    task automatic t_powerdown();
        drv_l(1, 0, 0, 0, 12'h010, 9'h055); step();
        chk("R2 left valid deselected", 16'(l_rvalid), 16'd0);
        chk("R2 left data deselected", 16'(l_rdata), 16'd0);
        idle_both();
        read_l(12'h010, 9'h1A5, "R2 no write");
    endtask

    task automatic t_drive_off();
        drv_r(0, 1, 1, 0, 12'h010, '0); step();
        chk("R6 right valid", 16'(r_rvalid), 16'd0);
        chk("R6 right data", 16'(r_rdata), 16'd0);
        idle_both();
    endtask

    task automatic t_busy();
        drv_l(0, 0, 1, 0, 12'h020, 9'h111); step();
        drv_l(0, 0, 1, 1, 12'h020, 9'h0F0); step();
        drv_l(1, 1, 1, 0, '0, '0);
        drv_r(0, 0, 1, 1, 12'h020, 9'h1EE); step();
        idle_both();
        read_r(12'h020, 9'h111, "R7 held writes ignored");
    endtask

    task automatic t_window();
        drv_l(0, 0, 1, 0, 12'h030, 9'h0AA); step();
        drv_l(0, 1, 1, 0, 12'h030, 9'h155); step();
        drv_l(1, 0, 1, 0, 12'h030, 9'h077); step();
        idle_both();
        read_l(12'h030, 9'h0AA, "R10 window closed");
    endtask

    task automatic t_collide();
        drv_l(0, 0, 1, 0, 12'h040, 9'h1C3);
        drv_r(0, 0, 1, 0, 12'h040, 9'h03C); step();
        idle_both();
        read_r(12'h040, 9'h1C3, "R8 left wins");
    endtask

    task automatic t_read_during_write();
        drv_l(0, 0, 1, 0, 12'h050, 9'h012); step();
        drv_l(0, 1, 0, 0, 12'h050, '0);
        drv_r(0, 0, 1, 0, 12'h050, 9'h1FE); step();
        chk("R9 old data valid", 16'(l_rvalid), 16'd1);
        chk("R9 old data", 16'(l_rdata), 16'h012);
        drv_r(1, 1, 1, 0, '0, '0); step();
        chk("R9 new data", 16'(l_rdata), 16'h1FE);
        idle_both();
    endtask

    task automatic t_parallel();
        drv_l(0, 0, 1, 0, 12'h060, 9'h101);
        drv_r(0, 1, 0, 0, 12'h010, '0); step();
        chk("R11 right valid", 16'(r_rvalid), 16'd1);
        chk("R11 right data", 16'(r_rdata), 16'h1A5);
        idle_both();
        read_r(12'h060, 9'h101, "R11 left write landed");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write_read();
        t_powerdown();
        t_drive_off();
        t_busy();
        t_window();
        t_collide();
        t_read_during_write();
        t_parallel();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule